// File: doc/BRIEF.md
# Wake-up and Watchdog Interval Timer

This block runs from a slow free-running oscillator of about 50 kHz and holds two independent interval counters. The wake-up counter raises a sticky interrupt flag each time its interval elapses. The flag can wake a core that sits in IDLE. The watchdog counter emits a one-cycle reset pulse when software fails to restart it within its timeout. Each counter has its own enable and its own 2-bit interval select. A low-power mode input decides which counter keeps running: the wake-up counter halts in STOP, and the watchdog either halts in STOP or keeps counting, as set by a configuration bit.

The wake-up side is a three-state machine. OFF moves to RUN on enable, or to HOLD if STOP is already present. RUN moves to HOLD when STOP arrives. HOLD moves back to RUN when STOP ends. Every state falls to OFF on disable. The watchdog is a four-state machine. OFF moves to RUN, or to FROZEN under STOP without run-in-stop. RUN moves to FROZEN under the same condition and to FIRE when the terminal count is reached. FROZEN moves back to RUN when the halt condition ends. FIRE always leaves after one cycle, to RUN or to FROZEN. A transition into or out of HOLD or FROZEN does not advance the count.

Top module: `wkwd_timer`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `wk_irq` and `wd_rst` are 0. A reset in mid-run clears a set flag.
- R2: The wake-up interval is N = 2^(WK_BASE_LOG2+wk_sel) cycles, which by default is 1024, 2048, 4096 or 8192 for wk_sel 0 to 3. The flag rises on clock edge N+1, counting the edge that first samples `wk_en` high as edge 1, and the count then repeats every N edges.
- R3: `wk_irq` stays 1 until a cycle with `wk_flag_clr`=1 clears it. If an interval ends in the same cycle as a clear, the flag stays 1.
- R4: With `pwr_mode`=01 (IDLE), the wake-up counter counts exactly as it does with 00 (active).
- R5: With `pwr_mode`=10 or 11 (STOP), the wake-up counter holds its value and the flag cannot rise. Counting resumes from the held value, and the edge that leaves STOP does not advance the count.
- R6: The watchdog timeout is M = 2^(WD_BASE_LOG2+wd_sel) cycles, which by default is 8192, 16384, 32768 or 65536. `wd_rst` is high for one cycle after edge M+1, where the enabling or clearing edge is edge 1. The counter then restarts, so the pulses repeat every M+1 edges.
- R7: A cycle with `wd_clr`=1 restarts the watchdog count from zero, and no pulse follows in the next cycle.
- R8: In STOP with `wd_run_in_stop`=1 the watchdog keeps counting. With `wd_run_in_stop`=0 it holds its value and gives no pulse, then resumes from that value, and the edge that leaves STOP does not advance the count.
- R9: Changing `wk_sel` or `wd_sel` restarts that counter from zero on the edge that sees the change.
- R10: A disabled counter is cleared and gives no new flag or pulse. On re-enable it starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwr_mode | input | 2 | 00 active, 01 IDLE, 10 or 11 STOP |
| wk_en | input | 1 | Wake-up counter enable |
| wk_sel | input | 2 | Wake-up interval select |
| wk_flag_clr | input | 1 | Write-1 clear of the wake-up flag |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Watchdog timeout select |
| wd_clr | input | 1 | Watchdog restart strobe |
| wd_run_in_stop | input | 1 | 1 keeps the watchdog counting in STOP |
| wk_irq | output | 1 | Sticky wake-up interrupt flag |
| wd_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions check, on every cycle, the properties that follow from one step of either state machine. These are: the pulse is one cycle wide, the flag stays set without a clear, nothing fires in STOP or while disabled, and a restart strobe suppresses the next pulse. Only the bench scenarios can show the exact interval lengths for every select value and mode, and that a count resumes correctly after STOP. They also cover the restart on a select change and the priority of a set over a clear. Each of these needs a count of edges over a full interval.

// File: rtl/wkwd_pkg.sv
package wkwd_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'b00,
        PM_IDLE     = 2'b01,
        PM_STOP     = 2'b10,
        PM_STOP_ALT = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        WK_OFF  = 2'd0,
        WK_RUN  = 2'd1,
        WK_HOLD = 2'd2
    } wk_state_e;

    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_RUN    = 2'd1,
        WD_FROZEN = 2'd2,
        WD_FIRE   = 2'd3
    } wd_state_e;

    // Last count value of an interval of 2^(base+sel) cycles.
    function automatic int unsigned span_last(input int unsigned base_log2,
                                              input logic [1:0]  sel);
        return (32'd1 << (base_log2 + 32'(sel))) - 32'd1;
    endfunction

endpackage

// File: rtl/wkwd_wake.sv
module wkwd_wake
    import wkwd_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    input  logic       halt,
    input  logic       flag_clr,
    output logic       flag
);
    localparam int unsigned CW = BASE_LOG2 + 3;

    wk_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt, term;
    logic [1:0]    sel_q;
    logic          sel_chg, hit;

    always_comb begin
        sel_chg = (sel != sel_q);
        term    = CW'(span_last(BASE_LOG2, sel));
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        hit     = 1'b0;
        unique case (state)
            WK_OFF: begin
                cnt_nxt = '0;
                if (en) nxt = halt ? WK_HOLD : WK_RUN;
            end
            WK_RUN: begin
                if (!en) begin
                    nxt     = WK_OFF;
                    cnt_nxt = '0;
                end else if (sel_chg) begin
                    cnt_nxt = '0;
                    if (halt) nxt = WK_HOLD;
                end else if (halt) begin
                    nxt = WK_HOLD;
                end else if (cnt == term) begin
                    cnt_nxt = '0;
                    hit     = 1'b1;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            WK_HOLD: begin
                if (!en) begin
                    nxt     = WK_OFF;
                    cnt_nxt = '0;
                end else begin
                    if (sel_chg) cnt_nxt = '0;
                    if (!halt)   nxt     = WK_RUN;
                end
            end
            default: begin
                nxt     = WK_OFF;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WK_OFF;
            cnt   <= '0;
            sel_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            sel_q <= sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

endmodule

// File: rtl/wkwd_dog.sv
module wkwd_dog
    import wkwd_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    input  logic       halt,
    input  logic       clr,
    output logic       fire
);
    localparam int unsigned CW = BASE_LOG2 + 3;

    wd_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt, term;
    logic [1:0]    sel_q;
    logic          sel_chg;

    always_comb begin
        sel_chg = (sel != sel_q);
        term    = CW'(span_last(BASE_LOG2, sel));
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            WD_OFF: begin
                cnt_nxt = '0;
                if (en) nxt = halt ? WD_FROZEN : WD_RUN;
            end
            WD_RUN: begin
                if (!en) begin
                    nxt     = WD_OFF;
                    cnt_nxt = '0;
                end else if (clr || sel_chg) begin
                    cnt_nxt = '0;
                    if (halt) nxt = WD_FROZEN;
                end else if (halt) begin
                    nxt = WD_FROZEN;
                end else if (cnt == term) begin
                    nxt     = WD_FIRE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            WD_FROZEN: begin
                if (!en) begin
                    nxt     = WD_OFF;
                    cnt_nxt = '0;
                end else begin
                    if (clr || sel_chg) cnt_nxt = '0;
                    if (!halt)          nxt     = WD_RUN;
                end
            end
            WD_FIRE: begin
                cnt_nxt = '0;
                if (!en)       nxt = WD_OFF;
                else if (halt) nxt = WD_FROZEN;
                else           nxt = WD_RUN;
            end
            default: begin
                nxt     = WD_OFF;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_OFF;
            cnt   <= '0;
            sel_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            sel_q <= sel;
        end
    end

    always_comb begin
        fire = (state == WD_FIRE);
    end

endmodule

// File: rtl/wkwd_timer.sv
module wkwd_timer
    import wkwd_pkg::*;
#(
    parameter int unsigned WK_BASE_LOG2 = 10,
    parameter int unsigned WD_BASE_LOG2 = 13
) (
    input  logic       clk_slow,
    input  logic       rst_n,
    input  logic [1:0] pwr_mode,
    input  logic       wk_en,
    input  logic [1:0] wk_sel,
    input  logic       wk_flag_clr,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    input  logic       wd_clr,
    input  logic       wd_run_in_stop,
    output logic       wk_irq,
    output logic       wd_rst
);
    pwr_mode_e pm;
    logic      in_stop, wk_halt, wd_halt;

    always_comb begin
        pm      = pwr_mode_e'(pwr_mode);
        in_stop = (pm == PM_STOP) || (pm == PM_STOP_ALT);
        wk_halt = in_stop;
        wd_halt = in_stop && !wd_run_in_stop;
    end

    wkwd_wake #(.BASE_LOG2(WK_BASE_LOG2)) u_wake (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .en       (wk_en),
        .sel      (wk_sel),
        .halt     (wk_halt),
        .flag_clr (wk_flag_clr),
        .flag     (wk_irq)
    );

    wkwd_dog #(.BASE_LOG2(WD_BASE_LOG2)) u_dog (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .en    (wd_en),
        .sel   (wd_sel),
        .halt  (wd_halt),
        .clr   (wd_clr),
        .fire  (wd_rst)
    );

endmodule

// File: rtl/wkwd_checks.sv
module wkwd_checks (
    input logic       clk_slow,
    input logic       rst_n,
    input logic [1:0] pwr_mode,
    input logic       wk_en,
    input logic       wk_flag_clr,
    input logic       wd_en,
    input logic       wd_clr,
    input logic       wd_run_in_stop,
    input logic       wk_irq,
    input logic       wd_rst
);
    logic stop_now;
    always_comb stop_now = (pwr_mode == 2'b10) || (pwr_mode == 2'b11);

    AST_WD_PULSE_SINGLE: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wd_rst |=> !wd_rst); // R6
    AST_WK_FLAG_STICKY: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (wk_irq && !wk_flag_clr) |=> wk_irq); // R3
    AST_WK_STOP_NO_RISE: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (stop_now && !wk_irq) |=> !wk_irq); // R5
    AST_WD_CLR_NO_PULSE: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wd_clr |=> !wd_rst); // R7
    AST_WD_STOP_FROZEN: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (stop_now && !wd_run_in_stop) |=> !wd_rst); // R8
    AST_WD_OFF_SILENT: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !wd_en |=> !wd_rst); // R10
    AST_WK_OFF_SILENT: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (!wk_en && !wk_irq) |=> !wk_irq); // R10

endmodule

bind wkwd_timer wkwd_checks u_wkwd_checks (
    .clk_slow       (clk_slow),
    .rst_n          (rst_n),
    .pwr_mode       (pwr_mode),
    .wk_en          (wk_en),
    .wk_flag_clr    (wk_flag_clr),
    .wd_en          (wd_en),
    .wd_clr         (wd_clr),
    .wd_run_in_stop (wd_run_in_stop),
    .wk_irq         (wk_irq),
    .wd_rst         (wd_rst)
);

// File: tb/test_wkwd_timer.sv
`timescale 1ns/1ps
module test_wkwd_timer;
    localparam int unsigned WKB = 4;
    localparam int unsigned WDB = 6;
    localparam int WN0 = 1 << WKB;
    localparam int WM0 = 1 << WDB;

    typedef struct packed {
        logic       unit;   // 0 wake-up, 1 watchdog
        logic [1:0] sel;
        logic [1:0] mode;
        logic       run;
        int         exp_k;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 2'd0, 2'b00, 1'b0, (WN0 << 0) + 1},
        '{1'b0, 2'd1, 2'b00, 1'b0, (WN0 << 1) + 1},
        '{1'b0, 2'd2, 2'b00, 1'b0, (WN0 << 2) + 1},
        '{1'b0, 2'd3, 2'b00, 1'b0, (WN0 << 3) + 1},
        '{1'b0, 2'd1, 2'b01, 1'b0, (WN0 << 1) + 1},
        '{1'b1, 2'd0, 2'b00, 1'b0, (WM0 << 0) + 1},
        '{1'b1, 2'd1, 2'b00, 1'b0, (WM0 << 1) + 1},
        '{1'b1, 2'd2, 2'b00, 1'b0, (WM0 << 2) + 1},
        '{1'b1, 2'd3, 2'b00, 1'b0, (WM0 << 3) + 1},
        '{1'b1, 2'd1, 2'b10, 1'b1, (WM0 << 1) + 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_mode = 2'b00;
    logic       wk_en = 1'b0, wk_flag_clr = 1'b0, wd_en = 1'b0, wd_clr = 1'b0;
    logic       wd_run_in_stop = 1'b0;
    logic [1:0] wk_sel = 2'd0, wd_sel = 2'd0;
    logic       wk_irq, wd_rst;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    wkwd_timer #(.WK_BASE_LOG2(WKB), .WD_BASE_LOG2(WDB)) i_wkwd_timer (
        .clk_slow(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
        .wk_en(wk_en), .wk_sel(wk_sel), .wk_flag_clr(wk_flag_clr),
        .wd_en(wd_en), .wd_sel(wd_sel), .wd_clr(wd_clr),
        .wd_run_in_stop(wd_run_in_stop), .wk_irq(wk_irq), .wd_rst(wd_rst)
    );

    task automatic check(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pwr_mode = 2'b00; wk_en = 1'b0; wk_sel = 2'd0;
        wk_flag_clr = 1'b0; wd_en = 1'b0; wd_sel = 2'd0; wd_clr = 1'b0;
        wd_run_in_stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            wk_flag_clr = 1'b0; wd_clr = 1'b0;
        end
    endtask

    // Counts edges until the chosen output is seen high; strobes last one edge.
    task automatic wait_out(input logic unit, output int k);
        k = 0;
        for (int i = 0; i < 4000; i++) begin
            step(1);
            k++;
            if ((unit == 1'b0) ? wk_irq : wd_rst) break;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        // R1: outputs quiet in and right after reset
        repeat (2) @(negedge clk);
        check("R1 wk_irq in reset", int'(wk_irq), 0);
        check("R1 wd_rst in reset", int'(wd_rst), 0);
        rst_n = 1'b1;
        step(1);
        check("R1 wk_irq after release", int'(wk_irq), 0);
        check("R1 wd_rst after release", int'(wd_rst), 0);

        // Table of interval vectors (R2, R4, R6, R8)
        for (int v = 0; v < 10; v++) begin
            string tag;
            do_reset();
            pwr_mode = VECS[v].mode;
            wd_run_in_stop = VECS[v].run;
            if (VECS[v].unit == 1'b0) begin
                wk_sel = VECS[v].sel; wk_en = 1'b1;
                tag = (VECS[v].mode == 2'b01) ? "R4 idle wake interval" : "R2 wake interval";
            end else begin
                wd_sel = VECS[v].sel; wd_en = 1'b1;
                tag = (VECS[v].mode[1]) ? "R8 watchdog runs in stop" : "R6 watchdog timeout";
            end
            wait_out(VECS[v].unit, k);
            check(tag, k, VECS[v].exp_k);
        end

        // R6: pulse width one cycle and repeat period M+1
        do_reset();
        wd_en = 1'b1;
        wait_out(1'b1, k);
        step(1);
        check("R6 pulse one cycle", int'(wd_rst), 0);
        wait_out(1'b1, k);
        check("R6 repeat period", k + 1, WM0 + 1);

        // R3: set wins over clear, flag sticky, clear works
        do_reset();
        wk_en = 1'b1;
        step(WN0);
        check("R3 no flag before interval", int'(wk_irq), 0);
        wk_flag_clr = 1'b1;
        step(1);
        check("R3 set beats clear", int'(wk_irq), 1);
        step(5);
        check("R3 flag sticky", int'(wk_irq), 1);
        wk_flag_clr = 1'b1;
        step(1);
        check("R3 clear by strobe", int'(wk_irq), 0);

        // R1: reset mid-run clears flag
        step(WN0);
        check("R1 flag set before reset", int'(wk_irq), 1);
        do_reset();
        check("R1 flag cleared by reset", int'(wk_irq), 0);

        // R5: wake-up halts in STOP and resumes
        do_reset();
        wk_en = 1'b1;
        step(5);
        pwr_mode = 2'b10;
        step(100);
        check("R5 no flag in stop", int'(wk_irq), 0);
        pwr_mode = 2'b00;
        wait_out(1'b0, k);
        check("R5 resume count", k, WN0 - 5 + 2);

        // R8: watchdog frozen in STOP (encoding 11) and resumes
        do_reset();
        wd_en = 1'b1;
        step(10);
        pwr_mode = 2'b11;
        step(300);
        check("R8 no pulse while frozen", int'(wd_rst), 0);
        pwr_mode = 2'b00;
        wait_out(1'b1, k);
        check("R8 resume count", k, WM0 - 10 + 2);

        // R7: clear restarts the watchdog
        do_reset();
        wd_en = 1'b1;
        step(40);
        wd_clr = 1'b1;
        wait_out(1'b1, k);
        check("R7 restart after clear", k, WM0 + 1);

        // R9: select change restarts each counter
        do_reset();
        wk_en = 1'b1;
        step(10);
        wk_sel = 2'd1;
        wait_out(1'b0, k);
        check("R9 wake select restart", k, (WN0 << 1) + 1);
        do_reset();
        wd_en = 1'b1;
        step(40);
        wd_sel = 2'd1;
        wait_out(1'b1, k);
        check("R9 watchdog select restart", k, (WM0 << 1) + 1);

        // R10: disable clears and silences
        do_reset();
        wk_en = 1'b1;
        step(10);
        wk_en = 1'b0;
        step(40);
        check("R10 wake disabled silent", int'(wk_irq), 0);
        wk_en = 1'b1;
        wait_out(1'b0, k);
        check("R10 wake restarts from zero", k, WN0 + 1);
        do_reset();
        wd_en = 1'b1;
        step(40);
        wd_en = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 200; i++) begin
                step(1);
                if (wd_rst) seen++;
            end
            check("R10 watchdog disabled silent", seen, 0);
        end
        wd_en = 1'b1;
        wait_out(1'b1, k);
        check("R10 watchdog restarts from zero", k, WM0 + 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule